// File: doc/BRIEF.md
# Dual-Set Blink Waveform Generator

This block produces square waves for a bank of output lines. It holds two independent timing sets. Each set has a high-time register and a low-time register, and each register holds a count of input clock cycles. Each set repeats its pattern without end: high for the high-time count, then low for the low-time count. A per-line routing mask gives each output line the waveform of one of the two sets. The resulting vector goes to the pin logic, which drives it onto the lines where blinking is wanted.

Software programs the block through a small register port. A write is a single-cycle strobe with a byte address. The read path is combinational. A new duration does not cut the phase in progress. Each set samples its register only when it enters a phase, so the next phase of that kind takes the new value. A duration of zero stands for the full counter range, 2^32 cycles, not for an empty phase.

Top module: `blink_wavegen`

## Requirements
- R1: After reset, all four duration registers read 1, the routing mask reads 0, and both sets start in the high phase, so every line is high in the first cycle and then toggles every cycle.
- R2: Registers sit at these byte offsets: 0x00 set A high time, 0x04 set A low time, 0x08 set B high time, 0x0C set B low time, 0x10 routing mask (bit i for line i). A written value reads back at the same offset in the next cycle.
- R3: A set's waveform stays high for exactly the high-time count of cycles, then low for exactly the low-time count, and repeats. The period is the sum of the two.
- R4: A duration register holding 0 gives a phase of 2^32 cycles. The counter steps down by one on every cycle of a phase.
- R5: Writing a duration while a phase is running leaves that phase unchanged. The value is taken when the set next enters the matching phase.
- R6: Routing mask bit value 0 gives line i the set A waveform, and bit value 1 gives it the set B waveform. A mask write takes effect in the cycle after the write.
- R7: The two sets run independently. A write to one set's registers never changes the other set's waveform timing.
- R8: A write to any offset other than the five above changes no register, and a read from such an offset returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; durations count its cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_addr | input | ADDR_W (5) | Byte offset of the write |
| wr_data | input | CNT_W (32) | Write data |
| rd_addr | input | ADDR_W (5) | Byte offset of the combinational read |
| rd_data | output | CNT_W (32) | Read data for rd_addr |
| blink_out | output | LINES (32) | Per-line blink waveform |

## Verification
A register write lands on the clock edge that samples the strobe. It can be read back in the next cycle. A routing change shows on blink_out in the cycle after that edge. A duration change first shows at the next phase boundary of that set, which can be many cycles later. The waveform output changes only at rising edges and has no output register, so the bench keeps a cycle model that steps on each rising edge and compares it with blink_out at every falling edge. Reads are sampled one time unit after rd_addr changes, and explicit edge-to-edge measurements count falling edges between transitions of one line.

// File: rtl/blink_pkg.sv
package blink_pkg;
   localparam int unsigned NUM_SETS   = 2;
   localparam int unsigned SET_STRIDE = 8;
   localparam int unsigned OFS_HIGH   = 0;
   localparam int unsigned OFS_LOW    = 4;
   localparam int unsigned OFS_ROUTE  = 16;

   typedef enum logic {
      SET_A = 1'b0,
      SET_B = 1'b1
   } set_id_e;
endpackage

// File: rtl/blink_regs.sv
module blink_regs
   import blink_pkg::*;
#(
   parameter int unsigned CNT_W     = 32,
   parameter int unsigned LINES     = 32,
   parameter int unsigned ADDR_W    = 5,
   parameter int unsigned RESET_DUR = 1
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               wr_en,
   input  logic [ADDR_W-1:0]                  wr_addr,
   input  logic [CNT_W-1:0]                   wr_data,
   input  logic [ADDR_W-1:0]                  rd_addr,
   output logic [CNT_W-1:0]                   rd_data,
   output logic [NUM_SETS-1:0][CNT_W-1:0]     dur_high,
   output logic [NUM_SETS-1:0][CNT_W-1:0]     dur_low,
   output logic [LINES-1:0]                   route_q
);
   localparam logic [CNT_W-1:0]  DUR_RST   = CNT_W'(RESET_DUR);
   localparam logic [ADDR_W-1:0] ROUTE_ADR = ADDR_W'(OFS_ROUTE);

   for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
      localparam logic [ADDR_W-1:0] HI_ADR = ADDR_W'(s * SET_STRIDE + OFS_HIGH);
      localparam logic [ADDR_W-1:0] LO_ADR = ADDR_W'(s * SET_STRIDE + OFS_LOW);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            dur_high[s] <= DUR_RST;
            dur_low[s]  <= DUR_RST;
         end else if (wr_en) begin
            if (wr_addr == HI_ADR) dur_high[s] <= wr_data;
            if (wr_addr == LO_ADR) dur_low[s]  <= wr_data;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         route_q <= '0;
      else if (wr_en && wr_addr == ROUTE_ADR)
         route_q <= wr_data[LINES-1:0];
   end

   always_comb begin
      rd_data = '0;
      for (int s = 0; s < NUM_SETS; s++) begin
         if (rd_addr == ADDR_W'(s * SET_STRIDE + OFS_HIGH)) rd_data = dur_high[s];
         if (rd_addr == ADDR_W'(s * SET_STRIDE + OFS_LOW))  rd_data = dur_low[s];
      end
      if (rd_addr == ROUTE_ADR) rd_data[LINES-1:0] = route_q;
   end
endmodule

// File: rtl/blink_phase_ctr.sv
module blink_phase_ctr #(
   parameter int unsigned CNT_W     = 32,
   parameter int unsigned RESET_DUR = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] len_high,
   input  logic [CNT_W-1:0] len_low,
   output logic             wave,
   output logic [CNT_W-1:0] cnt_q
);
   localparam logic [CNT_W-1:0] CNT_RST = CNT_W'(RESET_DUR) - 1'b1;

   logic [CNT_W-1:0] next_len;

   // Length of the phase that begins at the coming boundary.
   // Wrap-around of (0 - 1) yields the full 2^CNT_W cycle phase.
   assign next_len = wave ? len_low : len_high;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wave  <= 1'b1;
         cnt_q <= CNT_RST;
      end else if (cnt_q == '0) begin
         wave  <= ~wave;
         cnt_q <= next_len - 1'b1;
      end else begin
         cnt_q <= cnt_q - 1'b1;
      end
   end
endmodule

// File: rtl/blink_line_mux.sv
module blink_line_mux
   import blink_pkg::*;
#(
   parameter int unsigned LINES = 32
) (
   input  logic [LINES-1:0]    route,
   input  logic [NUM_SETS-1:0] wave,
   output logic [LINES-1:0]    line_out
);
   for (genvar l = 0; l < LINES; l++) begin : g_line
      assign line_out[l] = (set_id_e'(route[l]) == SET_B) ? wave[SET_B] : wave[SET_A];
   end
endmodule

// File: rtl/blink_wavegen.sv
module blink_wavegen
   import blink_pkg::*;
#(
   parameter int unsigned CNT_W     = 32,
   parameter int unsigned LINES     = 32,
   parameter int unsigned ADDR_W    = 5,
   parameter int unsigned RESET_DUR = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [CNT_W-1:0]  wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [CNT_W-1:0]  rd_data,
   output logic [LINES-1:0]  blink_out
);
   localparam int unsigned MIN_ADDR_W = $clog2(OFS_ROUTE + 1);

   if (LINES < 1 || LINES > CNT_W) begin : g_bad_lines
      $error("blink_wavegen: LINES must be in 1..CNT_W");
   end
   if (ADDR_W < MIN_ADDR_W) begin : g_bad_addr
      $error("blink_wavegen: ADDR_W too narrow for register offsets");
   end
   if (RESET_DUR < 1 || CNT_W < 2) begin : g_bad_dur
      $error("blink_wavegen: RESET_DUR must be at least 1 and CNT_W at least 2");
   end

   logic [NUM_SETS-1:0][CNT_W-1:0] dur_high;
   logic [NUM_SETS-1:0][CNT_W-1:0] dur_low;
   logic [NUM_SETS-1:0][CNT_W-1:0] cnt_q;
   logic [NUM_SETS-1:0]            wave;
   logic [LINES-1:0]               route_q;

   blink_regs #(
      .CNT_W(CNT_W), .LINES(LINES), .ADDR_W(ADDR_W), .RESET_DUR(RESET_DUR)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data),
      .dur_high(dur_high), .dur_low(dur_low), .route_q(route_q)
   );

   for (genvar s = 0; s < NUM_SETS; s++) begin : g_ctr
      blink_phase_ctr #(
         .CNT_W(CNT_W), .RESET_DUR(RESET_DUR)
      ) u_ctr (
         .clk(clk), .rst_n(rst_n),
         .len_high(dur_high[s]), .len_low(dur_low[s]),
         .wave(wave[s]), .cnt_q(cnt_q[s])
      );
   end

   blink_line_mux #(
      .LINES(LINES)
   ) u_mux (
      .route(route_q), .wave(wave), .line_out(blink_out)
   );
endmodule

// File: rtl/blink_wavegen_chk.sv
module blink_wavegen_chk
   import blink_pkg::*;
#(
   parameter int unsigned CNT_W  = 32,
   parameter int unsigned LINES  = 32,
   parameter int unsigned ADDR_W = 5
) (
   input logic                           clk,
   input logic                           rst_n,
   input logic                           wr_en,
   input logic [ADDR_W-1:0]              wr_addr,
   input logic [LINES-1:0]               blink_out,
   input logic [LINES-1:0]               route_q,
   input logic [NUM_SETS-1:0]            wave,
   input logic [NUM_SETS-1:0][CNT_W-1:0] cnt_q,
   input logic [NUM_SETS-1:0][CNT_W-1:0] dur_high,
   input logic [NUM_SETS-1:0][CNT_W-1:0] dur_low
);
   logic mapped;
   always_comb begin
      mapped = (wr_addr == ADDR_W'(OFS_ROUTE));
      for (int s = 0; s < NUM_SETS; s++) begin
         if (wr_addr == ADDR_W'(s * SET_STRIDE + OFS_HIGH)) mapped = 1'b1;
         if (wr_addr == ADDR_W'(s * SET_STRIDE + OFS_LOW))  mapped = 1'b1;
      end
   end

   p_first_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (wave == '1));

   p_route_a_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ((blink_out ^ {LINES{wave[0]}}) & ~route_q) == '0);

   p_route_b_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ((blink_out ^ {LINES{wave[1]}}) & route_q) == '0);

   p_unmapped_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !mapped) |=> ($stable(dur_high) && $stable(dur_low) && $stable(route_q)));

   for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
      p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (cnt_q[s] != '0) |=> $stable(wave[s]));

      p_toggle_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (cnt_q[s] == '0) |=> (wave[s] != $past(wave[s])));

      p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (cnt_q[s] != '0) |=> (cnt_q[s] == $past(cnt_q[s]) - 1'b1));

      p_load_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (cnt_q[s] == '0 && !wave[s]) |=> (cnt_q[s] == $past(dur_high[s]) - 1'b1));

      p_load_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (cnt_q[s] == '0 && wave[s]) |=> (cnt_q[s] == $past(dur_low[s]) - 1'b1));
   end
endmodule

bind blink_wavegen blink_wavegen_chk #(
   .CNT_W(CNT_W), .LINES(LINES), .ADDR_W(ADDR_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
   .blink_out(blink_out), .route_q(route_q), .wave(wave), .cnt_q(cnt_q),
   .dur_high(dur_high), .dur_low(dur_low)
);

// File: tb/blink_wavegen_tb.sv
module blink_wavegen_tb;
   localparam int CNT_W  = 32;
   localparam int LINES  = 32;
   localparam int ADDR_W = 5;

   logic              clk = 1'b0;
   logic              rst_n = 1'b1;
   logic              wr_en = 1'b0;
   logic [ADDR_W-1:0] wr_addr = '0;
   logic [CNT_W-1:0]  wr_data = '0;
   logic [ADDR_W-1:0] rd_addr = '0;
   logic [CNT_W-1:0]  rd_data;
   logic [LINES-1:0]  blink_out;

   int n_chk = 0;
   int n_bad = 0;
   bit armed = 0;
   bit done = 0;
   string cur_req = "R1";

   always #2 clk = ~clk;

   blink_wavegen u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .blink_out(blink_out)
   );

   // Reference model built from the requirements
   logic [CNT_W-1:0] m_hi_len [2];
   logic [CNT_W-1:0] m_lo_len [2];
   logic [LINES-1:0] m_route;
   bit               m_wave [2];
   longint           m_left [2];

   function automatic longint phase_cycles(logic [CNT_W-1:0] v);
      return (v == 0) ? 64'h1_0000_0000 : longint'(v);
   endfunction

   function automatic logic [LINES-1:0] exp_lines();
      logic [LINES-1:0] r;
      for (int l = 0; l < LINES; l++) r[l] = m_route[l] ? m_wave[1] : m_wave[0];
      return r;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < 2; s++) begin
            m_hi_len[s] = 1; m_lo_len[s] = 1; m_wave[s] = 1; m_left[s] = 1;
         end
         m_route = '0;
      end else begin
         for (int s = 0; s < 2; s++) begin
            if (m_left[s] == 1) begin
               m_wave[s] = !m_wave[s];
               m_left[s] = phase_cycles(m_wave[s] ? m_hi_len[s] : m_lo_len[s]);
            end else begin
               m_left[s] = m_left[s] - 1;
            end
         end
         if (wr_en) begin
            case (wr_addr)
               5'h00: m_hi_len[0] = wr_data;
               5'h04: m_lo_len[0] = wr_data;
               5'h08: m_hi_len[1] = wr_data;
               5'h0C: m_lo_len[1] = wr_data;
               5'h10: m_route = wr_data[LINES-1:0];
               default: ;
            endcase
         end
      end
   end

   task automatic check(string req, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (armed) check(cur_req, 64'(blink_out), 64'(exp_lines()));
   end

   task automatic wr(logic [ADDR_W-1:0] a, logic [CNT_W-1:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd_chk(string req, logic [ADDR_W-1:0] a, logic [CNT_W-1:0] exp);
      @(negedge clk);
      rd_addr = a;
      #1;
      check(req, 64'(rd_data), 64'(exp));
   endtask

   task automatic measure(int line, output int hi_n, output int lo_n);
      @(negedge clk);
      while (blink_out[line] !== 1'b0) @(negedge clk);
      while (blink_out[line] !== 1'b1) @(negedge clk);
      hi_n = 0;
      while (blink_out[line] === 1'b1) begin hi_n++; @(negedge clk); end
      lo_n = 0;
      while (blink_out[line] === 1'b0) begin lo_n++; @(negedge clk); end
   endtask

   task automatic do_reset();
      @(negedge clk);
      armed = 0;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      armed = 1;
   endtask

   initial begin
      int h, l;
      void'($urandom(32'h5EED_1234));
      #1 rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #0;
      // R1: first cycle after reset is high on every line
      check("R1", 64'(blink_out), 64'({LINES{1'b1}}));
      armed = 1;
      cur_req = "R1";
      rd_chk("R1", 5'h00, 1); rd_chk("R1", 5'h04, 1);
      rd_chk("R1", 5'h08, 1); rd_chk("R1", 5'h0C, 1);
      rd_chk("R1", 5'h10, 0);

      // R2: offsets and readback
      cur_req = "R2";
      wr(5'h00, 3); wr(5'h04, 5); wr(5'h08, 2); wr(5'h0C, 4);
      wr(5'h10, 32'h0F0F_00FF);
      rd_chk("R2", 5'h00, 3); rd_chk("R2", 5'h04, 5);
      rd_chk("R2", 5'h08, 2); rd_chk("R2", 5'h0C, 4);
      rd_chk("R2", 5'h10, 32'h0F0F_00FF);

      // R3: on/off lengths on a set A line (bit 8) and R7 on a set B line (bit 0)
      cur_req = "R3";
      measure(8, h, l);
      check("R3 high", 64'(h), 3); check("R3 low", 64'(l), 5);
      cur_req = "R7";
      measure(0, h, l);
      check("R7 high", 64'(h), 2); check("R7 low", 64'(l), 4);

      // R5: mid-phase write applies at the next boundary
      cur_req = "R5";
      while (blink_out[8] !== 1'b1) @(negedge clk);
      wr(5'h00, 7);
      measure(8, h, l);
      check("R5 high", 64'(h), 7); check("R5 low", 64'(l), 5);
      // R7: set B unchanged by the set A write
      measure(0, h, l);
      check("R7 high", 64'(h), 2); check("R7 low", 64'(l), 4);

      // R8: unmapped writes ignored, unmapped read is zero
      cur_req = "R8";
      wr(5'h14, 32'hDEAD_BEEF); wr(5'h1C, 32'h1234_5678); wr(5'h02, 32'h9);
      rd_chk("R8", 5'h14, 0); rd_chk("R8", 5'h00, 7); rd_chk("R8", 5'h04, 5);
      rd_chk("R8", 5'h08, 2); rd_chk("R8", 5'h0C, 4);
      rd_chk("R8", 5'h10, 32'h0F0F_00FF);

      // R6: routing change visible the cycle after the write
      cur_req = "R6";
      wr(5'h10, 32'hFFFF_FFFF);
      repeat (20) @(negedge clk);
      wr(5'h10, 32'hA5A5_5A5A);
      repeat (20) @(negedge clk);

      // Random mixes of durations and routing
      cur_req = "R7";
      for (int i = 0; i < 400; i++) begin
         int unsigned pick = $urandom % 5;
         if (pick == 4) wr(5'h10, $urandom);
         else wr(5'(pick * 4), 1 + ($urandom % 9));
         repeat ($urandom % 12) @(negedge clk);
      end

      // R4: zero duration gives a 2^32-cycle phase
      cur_req = "R4";
      wr(5'h10, 0);
      wr(5'h04, 1);
      wr(5'h00, 0);
      while (blink_out[5] !== 1'b0) @(negedge clk);
      while (blink_out[5] !== 1'b1) @(negedge clk);
      h = 0;
      for (int i = 0; i < 3000; i++) begin
         if (blink_out[5] === 1'b1) h++;
         @(negedge clk);
      end
      check("R4 held high", 64'(h), 3000);
      do_reset();
      cur_req = "R1";
      #0;
      rd_chk("R1", 5'h00, 1);
      repeat (10) @(negedge clk);

      done = 1;
      armed = 0;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end
endmodule